// File: doc/BRIEF.md
# SPI Master Frame Sequencer with Held Chip Select

This block is a serial peripheral interface master that turns frame commands into serial clock, data-out and chip-select activity. Each command carries its data word, its bit count, the index of the peripheral to address and a flag asking for the select to stay held into the next frame. The command is accepted through a valid/ready handshake. The shape of the frame comes from a set of configuration inputs that are captured with each command:

- the clock polarity and phase;
- the half-period of the serial clock;
- three guard intervals, all counted in system clocks:
  - lead: from select assertion to the first clock edge;
  - trail: from the last clock edge to select negation;
  - gap: the minimum time the select stays negated.

Data is shifted most significant bit first. The word received on the data-in line is returned right-aligned, together with a one-cycle valid strobe.

When a frame asks for the select to be held, the next command can follow it without releasing the select. The next command must be waiting when the trail interval ends, it must address the same peripheral and its configuration must be unchanged. In that case the gap interval is skipped, and the next frame's first clock edge follows the previous last edge after exactly the trail interval plus the lead interval. If any of these conditions fails, the boundary is an ordinary one: the select is negated and the gap interval is applied.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset, every select output is high, the serial clock is low, rx_valid is low and cmd_ready is high.
- R2: Frame length is cmd_len bits, clamped to the range 4 to 16. The low cmd_len bits of cmd_data go out on spi_mosi, most significant bit first.
- R3: The serial clock rests at the captured polarity during the lead, trail and gap intervals and at the end of every frame. A frame has exactly twice its length in clock edges, and consecutive edges inside a frame are cfg_half clocks apart.
- R4: With phase 0, the first bit is on spi_mosi when the frame is accepted and data changes on trailing edges. With phase 1, data changes on leading edges. The peripheral samples on the other edge, and the received word, with its first bit in the highest frame bit, appears on rx_data.
- R5: The first clock edge comes exactly cfg_csc clocks after the select falls. The select rises exactly cfg_asc clocks after the last clock edge.
- R6: A cfg_csc or cfg_asc value of 0 means 2 clocks each, so the two default to 4 clocks together. A cfg_half or cfg_dt value of 0 means 1 clock.
- R7: A frame without the hold flag ends with its select negated. When the next command is already waiting, the select is re-asserted exactly cfg_dt clocks after negation; otherwise it is re-asserted no earlier than that.
- R8: A held frame followed by a waiting command on the same select, with identical configuration, keeps the select low throughout. The next first edge then comes exactly (trail + lead) clocks after the previous last edge.
- R9: A held frame followed by a command to a different select is treated as an ordinary boundary, with negation and the gap interval.
- R10: A held frame followed by a command with any configuration field changed is treated as an ordinary boundary.
- R11: A held frame with no command waiting when its trail interval ends negates its select at that point and applies the gap interval.
- R12: Only the addressed select line, spi_cs_n bit cmd_sel, goes low (active low); all others stay high.
- R13: rx_valid is a single-cycle pulse, raised in the cycle of each frame's last clock edge and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_data | input | MAXLEN | Word to send, right-aligned |
| cmd_len | input | LW | Bit count of the frame (clamped 4..MAXLEN) |
| cmd_sel | input | SW | Index of the select line to drive |
| cmd_cont | input | 1 | Keep the select held into the next frame |
| cfg_cpol | input | 1 | Serial clock rest level |
| cfg_cpha | input | 1 | Clock phase (0: change data on trailing edge, 1: on leading edge) |
| cfg_half | input | CW | Serial clock half-period in clocks (0 means 1) |
| cfg_csc | input | CW | Select-to-first-edge clocks (0 means 2) |
| cfg_asc | input | CW | Last-edge-to-negation clocks (0 means 2) |
| cfg_dt | input | CW | Minimum negated time in clocks (0 means 1) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NSEL | Active-low select lines |
| rx_data | output | MAXLEN | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |

## Verification
The assertions assume a source that keeps cmd_data, cmd_len, cmd_sel, cmd_cont and the configuration inputs stable while cmd_valid waits for cmd_ready. They also assume that cmd_sel indexes an existing line, and that the peripheral changes spi_miso only between sampling edges. The bench's driver changes its inputs only at the falling system clock edge, and holds them until the handshake completes. Its peripheral model updates spi_miso only after it has observed a sampling edge, and its select indices are drawn from the lines that exist. Random frames reuse the previous frame's select and configuration often enough that held boundaries, changed-select fallbacks and changed-configuration fallbacks all occur.

// File: rtl/spi_cs_seq_pkg.sv
package spi_cs_seq_pkg;
  localparam int CW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL,
    ST_GAP
  } seq_state_e;

  typedef struct packed {
    logic          cpol;
    logic          cpha;
    logic [CW-1:0] half;
    logic [CW-1:0] csc;
    logic [CW-1:0] asc;
    logic [CW-1:0] dt;
  } frame_cfg_t;

  function automatic logic [CW-1:0] or_default(input logic [CW-1:0] v, input logic [CW-1:0] d);
    return (v == '0) ? d : v;
  endfunction
endpackage

// File: rtl/spi_cs_seq_ctrl.sv
module spi_cs_seq_ctrl
  import spi_cs_seq_pkg::*;
#(
  parameter int NSEL    = 4,
  parameter int MAXLEN  = 16,
  parameter int MINLEN  = 4,
  parameter int CSC_DEF = 2,
  parameter int ASC_DEF = 2,
  localparam int LW = $clog2(MAXLEN + 1),
  localparam int SW = $clog2(NSEL),
  localparam int EW = LW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [LW-1:0]   cmd_len,
  input  logic [SW-1:0]   cmd_sel,
  input  logic            cmd_cont,
  input  frame_cfg_t      cfg,
  output logic            sck,
  output logic [NSEL-1:0] cs_n,
  output logic            accept,
  output logic [LW-1:0]   len_clamped,
  output logic            smp,
  output logic            shf,
  output logic            fin
);
  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic [EW-1:0] ecnt;
  frame_cfg_t    cur;
  logic [LW-1:0] len_q;
  logic [SW-1:0] sel_q;
  logic          cont_q;
  logic          tick, cont_ok, edge_stb, edge_lead, edge_last;

  always_comb begin
    if (cmd_len < LW'(MINLEN))      len_clamped = LW'(MINLEN);
    else if (cmd_len > LW'(MAXLEN)) len_clamped = LW'(MAXLEN);
    else                            len_clamped = cmd_len;
  end

  assign tick    = (cnt == '0);
  assign cont_ok = cont_q && (cmd_sel == sel_q) && (cfg == cur);

  always_comb begin
    case (st)
      ST_IDLE:  cmd_ready = 1'b1;
      ST_GAP:   cmd_ready = tick;
      ST_TRAIL: cmd_ready = tick && cont_ok;
      default:  cmd_ready = 1'b0;
    endcase
  end

  assign accept    = cmd_valid && cmd_ready;
  assign edge_stb  = ((st == ST_LEAD) || (st == ST_XFER)) && tick;
  assign edge_lead = ~ecnt[0];
  assign edge_last = ((ecnt + EW'(1)) == {len_q, 1'b0});
  assign smp       = edge_stb && (edge_lead ^ cur.cpha);
  assign shf       = edge_stb && !(edge_lead ^ cur.cpha) && !edge_last;
  assign fin       = edge_stb && edge_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      ecnt   <= '0;
      cur    <= '0;
      len_q  <= LW'(MINLEN);
      sel_q  <= '0;
      cont_q <= 1'b0;
      sck    <= 1'b0;
      cs_n   <= '1;
    end else if (accept) begin
      cur    <= cfg;
      len_q  <= len_clamped;
      sel_q  <= cmd_sel;
      cont_q <= cmd_cont;
      cs_n   <= ~(NSEL'(1) << cmd_sel);
      sck    <= cfg.cpol;
      st     <= ST_LEAD;
      cnt    <= or_default(cfg.csc, CW'(CSC_DEF)) - 1'b1;
      ecnt   <= '0;
    end else begin
      case (st)
        ST_IDLE: sck <= cfg.cpol;
        ST_LEAD, ST_XFER: begin
          if (tick) begin
            sck  <= ~sck;
            ecnt <= ecnt + EW'(1);
            if (edge_last) begin
              st  <= ST_TRAIL;
              cnt <= or_default(cur.asc, CW'(ASC_DEF)) - 1'b1;
            end else begin
              st  <= ST_XFER;
              cnt <= or_default(cur.half, CW'(1)) - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_n <= '1;
            st   <= ST_GAP;
            cnt  <= or_default(cur.dt, CW'(1)) - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (tick) st <= ST_IDLE;
          else      cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R12: at most one select line active
  p_one_select_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  // R3: clock at rest outside the shifting window
  p_sck_rest_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LEAD || st == ST_TRAIL || st == ST_GAP) |-> (sck == cur.cpol));
  // R8: select does not move while bits are being shifted
  p_cs_held_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER) |=> $stable(cs_n));
  // R7: select negated throughout the gap interval
  p_gap_deselected_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GAP) |-> (cs_n == '1));
endmodule

// File: rtl/spi_cs_seq_tx.sv
module spi_cs_seq_tx #(
  parameter int MAXLEN = 16,
  localparam int LW = $clog2(MAXLEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MAXLEN-1:0] data,
  input  logic [LW-1:0]     len,
  input  logic              cpha,
  input  logic              shift,
  output logic              mosi
);
  logic [MAXLEN-1:0] sh;
  logic [MAXLEN-1:0] aligned;

  assign aligned = data << (LW'(MAXLEN) - len);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      mosi <= 1'b0;
    end else if (load) begin
      if (!cpha) begin
        mosi <= aligned[MAXLEN-1];
        sh   <= aligned << 1;
      end else begin
        sh <= aligned;
      end
    end else if (shift) begin
      mosi <= sh[MAXLEN-1];
      sh   <= sh << 1;
    end
  end

  // R4: data line only moves at a load or a change edge
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(load || shift) |=> $stable(mosi));
endmodule

// File: rtl/spi_cs_seq_rx.sv
module spi_cs_seq_rx #(
  parameter int MAXLEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic              done,
  input  logic              miso,
  output logic [MAXLEN-1:0] rx_data,
  output logic              rx_valid
);
  logic [MAXLEN-1:0] sh;
  logic [MAXLEN-1:0] sh_next;

  assign sh_next = {sh[MAXLEN-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= done;
      if (clear)       sh <= '0;
      else if (sample) sh <= sh_next;
      if (done) rx_data <= sample ? sh_next : sh;
    end
  end

  // R13: strobe lasts one cycle
  p_rx_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import spi_cs_seq_pkg::*;
#(
  parameter int NSEL    = 4,
  parameter int MAXLEN  = 16,
  parameter int MINLEN  = 4,
  parameter int CSC_DEF = 2,
  parameter int ASC_DEF = 2,
  localparam int LW = $clog2(MAXLEN + 1),
  localparam int SW = $clog2(NSEL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [MAXLEN-1:0] cmd_data,
  input  logic [LW-1:0]     cmd_len,
  input  logic [SW-1:0]     cmd_sel,
  input  logic              cmd_cont,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [CW-1:0]     cfg_half,
  input  logic [CW-1:0]     cfg_csc,
  input  logic [CW-1:0]     cfg_asc,
  input  logic [CW-1:0]     cfg_dt,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NSEL-1:0]   spi_cs_n,
  output logic [MAXLEN-1:0] rx_data,
  output logic              rx_valid
);
  frame_cfg_t    cfg_in;
  logic          accept, smp, shf, fin;
  logic [LW-1:0] len_c;

  assign cfg_in = '{cpol: cfg_cpol, cpha: cfg_cpha, half: cfg_half,
                    csc: cfg_csc, asc: cfg_asc, dt: cfg_dt};

  spi_cs_seq_ctrl #(
    .NSEL(NSEL), .MAXLEN(MAXLEN), .MINLEN(MINLEN),
    .CSC_DEF(CSC_DEF), .ASC_DEF(ASC_DEF)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_len(cmd_len), .cmd_sel(cmd_sel), .cmd_cont(cmd_cont), .cfg(cfg_in),
    .sck(spi_sck), .cs_n(spi_cs_n), .accept(accept), .len_clamped(len_c),
    .smp(smp), .shf(shf), .fin(fin)
  );

  spi_cs_seq_tx #(.MAXLEN(MAXLEN)) u_tx (
    .clk(clk), .rst(rst), .load(accept), .data(cmd_data), .len(len_c),
    .cpha(cfg_cpha), .shift(shf), .mosi(spi_mosi)
  );

  spi_cs_seq_rx #(.MAXLEN(MAXLEN)) u_rx (
    .clk(clk), .rst(rst), .clear(accept), .sample(smp), .done(fin),
    .miso(spi_miso), .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: tb/spi_cs_sequencer_test.sv
module spi_cs_sequencer_test;
  localparam int NFR = 72;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = '0;
  logic [4:0]  cmd_len = 5'd8;
  logic [1:0]  cmd_sel = '0;
  logic        cmd_cont = 1'b0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0]  cfg_half = 8'd1, cfg_csc = '0, cfg_asc = '0, cfg_dt = 8'd1;
  logic        spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [3:0]  spi_cs_n;
  logic [15:0] rx_data;
  logic        rx_valid;

  spi_cs_sequencer uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_len(cmd_len), .cmd_sel(cmd_sel), .cmd_cont(cmd_cont),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_half(cfg_half), .cfg_csc(cfg_csc),
    .cfg_asc(cfg_asc), .cfg_dt(cfg_dt), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always #2 clk = ~clk;

  logic [15:0] fr_data [NFR];
  logic [15:0] fr_miso [NFR];
  int          fr_len  [NFR];
  int          fr_sel  [NFR];
  bit          fr_cont [NFR];
  bit          fr_wait [NFR];
  bit          fr_cpol [NFR];
  bit          fr_cpha [NFR];
  int          fr_half [NFR];
  int          fr_csc  [NFR];
  int          fr_asc  [NFR];
  int          fr_dt   [NFR];

  int checks = 0, fails = 0;
  bit done = 0;
  int fi = 0, rx_cnt = 0, edges = 0, sbit = 0;
  int cyc = 0, t_start = 0, t_edge = 0, t_last = 0, t_rise = 0;
  bit have_rise = 0, by_fall = 0, rx_expect_now;
  logic [3:0]  p_cs = 4'hF;
  logic        p_sck = 1'b0;
  logic [15:0] got = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int effl(int i);
    if (fr_len[i] < 4) return 4;
    if (fr_len[i] > 16) return 16;
    return fr_len[i];
  endfunction
  function automatic int dflt(int v, int d);
    return (v == 0) ? d : v;
  endfunction
  function automatic logic [15:0] mask(int i);
    return 16'hFFFF >> (16 - effl(i));
  endfunction
  function automatic bit same_cfg(int a, int b);
    return fr_cpol[a] == fr_cpol[b] && fr_cpha[a] == fr_cpha[b] && fr_half[a] == fr_half[b]
        && fr_csc[a] == fr_csc[b] && fr_asc[a] == fr_asc[b] && fr_dt[a] == fr_dt[b];
  endfunction
  function automatic bit exp_cont(int i);
    if (i == 0 || i >= NFR) return 0;
    return fr_cont[i-1] && !fr_wait[i] && fr_sel[i] == fr_sel[i-1] && same_cfg(i, i-1);
  endfunction
  function automatic string gap_tag(int i);
    if (fr_wait[i]) return "R11";
    if (fr_cont[i-1] && fr_sel[i] != fr_sel[i-1]) return "R9";
    if (fr_cont[i-1] && !same_cfg(i, i-1)) return "R10";
    return "R7";
  endfunction

  // Frame plan: directed corner cases first, then seeded random frames
  task automatic setf(int i, int sel, int len, bit cont, bit cpol, bit cpha,
                      int half, int csc, int asc, int dt, bit wt);
    fr_sel[i] = sel; fr_len[i] = len; fr_cont[i] = cont; fr_cpol[i] = cpol;
    fr_cpha[i] = cpha; fr_half[i] = half; fr_csc[i] = csc; fr_asc[i] = asc;
    fr_dt[i] = dt; fr_wait[i] = wt;
    fr_data[i] = 16'($urandom); fr_miso[i] = 16'($urandom);
  endtask

  task automatic build_plan();
    void'($urandom(32'h5eed_1234));
    setf(0,  1, 8,  1, 0, 0, 2, 0, 0, 3, 0);
    setf(1,  1, 3,  1, 0, 0, 2, 0, 0, 3, 0);  // R2 clamp up, R8 and R6 held gap of 4
    setf(2,  1, 16, 1, 0, 0, 2, 0, 0, 3, 0);
    setf(3,  2, 8,  1, 0, 0, 2, 0, 0, 3, 0);  // R9 different select
    setf(4,  2, 6,  1, 0, 0, 3, 0, 0, 3, 0);  // R10 changed config
    setf(5,  2, 31, 0, 0, 0, 3, 0, 0, 3, 1);  // R11 nothing waiting, R2 clamp down
    setf(6,  0, 8,  1, 1, 1, 1, 1, 1, 0, 0);
    setf(7,  0, 9,  0, 1, 1, 1, 1, 1, 0, 0);  // R8 phase 1 polarity 1
    setf(8,  3, 7,  0, 1, 0, 0, 3, 2, 2, 0);  // R7 ordinary boundary
    setf(9,  3, 5,  1, 0, 1, 2, 2, 3, 1, 0);
    setf(10, 3, 12, 1, 0, 1, 2, 2, 3, 1, 0);
    setf(11, 3, 4,  0, 0, 1, 2, 2, 3, 1, 0);
    for (int i = 12; i < NFR; i++) begin
      bit nc;
      nc = ($urandom_range(3) == 0);
      setf(i, ($urandom_range(1) == 0) ? fr_sel[i-1] : int'($urandom_range(3)),
           int'($urandom_range(18, 2)), 1'($urandom_range(1)),
           nc ? 1'($urandom_range(1)) : fr_cpol[i-1],
           nc ? 1'($urandom_range(1)) : fr_cpha[i-1],
           nc ? int'($urandom_range(3)) : fr_half[i-1],
           nc ? int'($urandom_range(3)) : fr_csc[i-1],
           nc ? int'($urandom_range(3)) : fr_asc[i-1],
           nc ? int'($urandom_range(3)) : fr_dt[i-1],
           ($urandom_range(9) == 0));
    end
  endtask

  // Monitor and peripheral model, sampling away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      bit fell, rose, ech;
      cyc++;
      fell = (p_cs == 4'hF) && (spi_cs_n != 4'hF);
      rose = (p_cs != 4'hF) && (spi_cs_n == 4'hF);
      ech  = (spi_sck != p_sck) && !fell && (spi_cs_n != 4'hF) && (p_cs != 4'hF);
      rx_expect_now = 0;
      if (fell && fi < NFR) begin
        by_fall = 1; t_start = cyc; edges = 0;
        chk(spi_cs_n == ~(4'b1 << fr_sel[fi]), "R12", spi_cs_n, ~(4'b1 << fr_sel[fi]));
        chk(spi_sck == fr_cpol[fi], "R3", spi_sck, fr_cpol[fi]);
        if (fi > 0) begin
          chk(!exp_cont(fi), "R8", 0, 1);
          if (have_rise) begin
            if (fr_wait[fi]) chk(cyc - t_rise >= dflt(fr_dt[fi-1], 1), "R11", cyc - t_rise, dflt(fr_dt[fi-1], 1));
            else chk(cyc - t_rise == dflt(fr_dt[fi-1], 1), gap_tag(fi), cyc - t_rise, dflt(fr_dt[fi-1], 1));
          end
        end
      end
      if (rose && fi > 0) begin
        chk(spi_sck == fr_cpol[fi-1], "R3", spi_sck, fr_cpol[fi-1]);
        chk(cyc - t_last == dflt(fr_asc[fi-1], 2), fr_cont[fi-1] ? "R11" : "R5",
            cyc - t_last, dflt(fr_asc[fi-1], 2));
        if (fi < NFR) chk(!exp_cont(fi), "R8", 1, 0);
        t_rise = cyc; have_rise = 1;
      end
      if (ech && fi < NFR) begin
        edges++;
        if (edges == 1) begin
          if (by_fall) begin
            chk(cyc - t_start == dflt(fr_csc[fi], 2), (fr_csc[fi] == 0) ? "R6" : "R5",
                cyc - t_start, dflt(fr_csc[fi], 2));
          end else begin
            chk(exp_cont(fi), "R8", 1, 0);
            chk(cyc - t_last == dflt(fr_asc[fi-1], 2) + dflt(fr_csc[fi], 2),
                (fr_asc[fi-1] == 0 && fr_csc[fi] == 0) ? "R6" : "R8",
                cyc - t_last, dflt(fr_asc[fi-1], 2) + dflt(fr_csc[fi], 2));
          end
        end else begin
          chk(cyc - t_edge == dflt(fr_half[fi], 1), "R3", cyc - t_edge, dflt(fr_half[fi], 1));
        end
        t_edge = cyc;
        if (fr_cpha[fi] ? (edges % 2 == 0) : (edges % 2 == 1)) begin
          got = {got[14:0], spi_mosi};
          sbit++;
        end
        if (edges == 2 * effl(fi)) begin
          chk(got == (fr_data[fi] & mask(fi)), "R2", got, fr_data[fi] & mask(fi));
          chk(spi_sck == fr_cpol[fi], "R3", spi_sck, fr_cpol[fi]);
          chk(rx_valid == 1'b1, "R13", rx_valid, 1);
          chk(rx_data == (fr_miso[fi] & mask(fi)), "R4", rx_data, fr_miso[fi] & mask(fi));
          rx_expect_now = 1; rx_cnt++;
          t_last = cyc; fi++; edges = 0; sbit = 0; got = '0; by_fall = 0;
        end
      end
      if (rx_valid && !rx_expect_now) chk(0, "R13", 1, 0);
      p_cs = spi_cs_n; p_sck = spi_sck;
      spi_miso = (fi < NFR) ? fr_miso[fi][effl(fi) - 1 - sbit] : 1'b0;
    end
  end

  initial begin
    build_plan();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(spi_cs_n == 4'hF, "R1", spi_cs_n, 15);
    chk(spi_sck == 1'b0, "R1", spi_sck, 0);
    chk(rx_valid == 1'b0, "R1", rx_valid, 0);
    chk(cmd_ready == 1'b1, "R1", cmd_ready, 1);
    @(negedge clk);
    for (int i = 0; i < NFR; i++) begin
      if (fr_wait[i]) repeat (300) @(negedge clk);
      cmd_data = fr_data[i]; cmd_len = 5'(fr_len[i]); cmd_sel = 2'(fr_sel[i]);
      cmd_cont = fr_cont[i]; cfg_cpol = fr_cpol[i]; cfg_cpha = fr_cpha[i];
      cfg_half = 8'(fr_half[i]); cfg_csc = 8'(fr_csc[i]); cfg_asc = 8'(fr_asc[i]);
      cfg_dt = 8'(fr_dt[i]); cmd_valid = 1'b1;
      #1;
      while (!cmd_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (fi < NFR) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(spi_cs_n == 4'hF, "R11", spi_cs_n, 15);
    chk(rx_cnt == NFR, "R13", rx_cnt, NFR);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d frames", fi, NFR);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule